// File: doc/BRIEF.md
# Divided-Clock Periodic Timer

This peripheral counts a 256 Hz timing pulse, supplied as a one-cycle enable in the system clock domain, with an 8-bit counter. As the count rolls past multiples of 8, 32 and 128, and when it wraps to zero, it raises four periodic events at 32 Hz, 8 Hz, 2 Hz and 1 Hz. Each event sets its own sticky flag. Software clears a flag by writing 1 to its bit. A separate enable mask selects which flags drive the single registered interrupt line.

Software starts and stops the timer through a mode register, and can zero the counter there. Stopping is not immediate. After a stop is written, the counter advances exactly once more, on the next 256 Hz pulse, and then halts. Any event boundary crossed by that last step still sets its flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and the timer is stopped, so pulses on `tick_i` leave the count at 0.
- R2: While running, each `tick_i` pulse adds 1 to the count, which wraps from 255 to 0. Address 1 returns the count, with bit 0 toggling at 128 Hz and bit 7 at 1 Hz. Writes to address 1 are ignored.
- R3: A count step sets flag bits at address 3 according to the new count: bit 0 when it is a multiple of 8, bit 1 when a multiple of 32, bit 2 when a multiple of 128, and bit 3 when it is 0. The flags are readable in the cycle after the pulse.
- R4: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R5: If an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Flags are set whatever the enable mask at address 2 (bits 3:0, same order as the flags) holds. `irq_o` equals the OR of (flag AND enable) as it was one cycle earlier.
- R7: Writing 0 to mode bit 0 while the timer runs allows exactly one more count, on the next pulse, and then the count holds. Events from that final count set their flags.
- R8: Writing 1 to mode bit 1 (address 0) zeroes the count in the next cycle. This takes precedence over a pulse in the same cycle and sets no flag. Bit 1 always reads 0.
- R9: Mode bit 0 is the run request and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 256 Hz count enable, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 mode, 1 count, 2 enable, 3 flags |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A write or a pulse takes effect at the clock edge where it is presented. The count, flags, enable and mode readback therefore show the new value one cycle later. `irq_o` adds one more register, so it reflects the flag and enable state of the previous cycle. The bench drives each stimulus for one cycle and updates its reference model at that same edge. It then reads every register and `irq_o` combinationally near the following falling edge, where each of the due values must already be visible.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int CNT_W  = 8;
  localparam int NUM_EV = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  // low count bits that must be zero after a step for each event (32, 8, 2, 1 Hz)
  localparam int EV_BITS [NUM_EV] = '{3, 5, 7, 8};

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE  = 2'd0,
    REG_COUNT = 2'd1,
    REG_IEN   = 2'd2,
    REG_IFLAG = 2'd3
  } reg_addr_e;

  localparam int MODE_RUN_BIT = 0;
  localparam int MODE_CLR_BIT = 1;
endpackage

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W  = tt_pkg::CNT_W,
  parameter int NUM_EV = tt_pkg::NUM_EV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              mode_wr_i,
  input  logic              run_wd_i,
  input  logic              clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              run_o,
  output logic [NUM_EV-1:0] ev_o
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             run_q, pend_q, pend_d, adv;

  assign adv     = tick_i && (run_q || pend_q) && !clr_i;
  assign cnt_nxt = cnt_q + CNT_W'(1);

  // stop request: one more count on the next tick, then halt
  always_comb begin
    if (mode_wr_i) pend_d = !run_wd_i && (run_q || (pend_q && !tick_i));
    else           pend_d = pend_q && !tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (mode_wr_i) run_q <= run_wd_i;
      if (clr_i)     cnt_q <= '0;
      else if (adv)  cnt_q <= cnt_nxt;
    end
  end

  for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
    localparam logic [CNT_W-1:0] Mask = CNT_W'((64'd1 << tt_pkg::EV_BITS[k]) - 64'd1);
    assign ev_o[k] = adv && ((cnt_nxt & Mask) == '0);
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !pend_q && !clr_i) |=> $stable(cnt_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !clr_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_stop_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && tick_i && !mode_wr_i) |=> !pend_q);
  assert_clr_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/tt_irq.sv
module tt_irq #(
  parameter int NUM_EV = tt_pkg::NUM_EV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              en_wr_i,
  input  logic              flag_wr_i,
  input  logic [NUM_EV-1:0] wdata_i,
  output logic [NUM_EV-1:0] en_o,
  output logic [NUM_EV-1:0] flag_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] en_q, flag_q, clr_mask;
  logic              irq_q;

  assign clr_mask = flag_wr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (en_wr_i) en_q <= wdata_i;
      flag_q <= (flag_q & ~clr_mask) | ev_i;  // set beats clear
      irq_q  <= |(flag_q & en_q);
    end
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  assert_no_spurious_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr_i |=> (flag_q & $past(flag_q)) == $past(flag_q));
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> (flag_q & $past(ev_i)) == $past(ev_i));
  assert_irq_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(flag_o & en_o)));
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W  = tt_pkg::CNT_W,
  parameter int NUM_EV = tt_pkg::NUM_EV,
  parameter int DATA_W = tt_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic              mode_wr, clr, run;
  logic [CNT_W-1:0]  count;
  logic [NUM_EV-1:0] ev, en, flag;
  reg_addr_e         ra;

  assign ra      = reg_addr_e'(addr_i);
  assign mode_wr = wr_en_i && (ra == REG_MODE);
  assign clr     = mode_wr && wdata_i[MODE_CLR_BIT];

  tt_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .mode_wr_i(mode_wr),
    .run_wd_i (wdata_i[MODE_RUN_BIT]),
    .clr_i    (clr),
    .count_o  (count),
    .run_o    (run),
    .ev_o     (ev)
  );

  tt_irq #(.NUM_EV(NUM_EV)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .en_wr_i  (wr_en_i && (ra == REG_IEN)),
    .flag_wr_i(wr_en_i && (ra == REG_IFLAG)),
    .wdata_i  (wdata_i[NUM_EV-1:0]),
    .en_o     (en),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (ra)
      REG_MODE:  rdata_o = DATA_W'(run);
      REG_COUNT: rdata_o = DATA_W'(count);
      REG_IEN:   rdata_o = DATA_W'(en);
      default:   rdata_o = DATA_W'(flag);
    endcase
  end

  assert_mode_rb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> run == $past(wdata_i[MODE_RUN_BIT]));
endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  bit       m_run, m_pend, m_irq;
  bit [7:0] m_cnt;
  bit [3:0] m_en, m_flag;

  always #2.5 clk_i = ~clk_i;

  tick_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic bit [7:0] exp_reg(input bit [1:0] a);
    case (a)
      2'd0:    return {7'd0, m_run};
      2'd1:    return m_cnt;
      2'd2:    return {4'd0, m_en};
      default: return {4'd0, m_flag};
    endcase
  endfunction

  function automatic void model_step(input bit tk, input bit wr, input bit [1:0] a, input bit [7:0] d);
    bit modew, clr, adv, npend;
    bit [7:0] nx;
    bit [3:0] ev;
    modew = wr && a == 2'd0;
    clr   = modew && d[1];
    adv   = tk && (m_run || m_pend) && !clr;
    nx    = m_cnt + 8'd1;
    ev    = adv ? {nx == 8'd0, nx[6:0] == 7'd0, nx[4:0] == 5'd0, nx[2:0] == 3'd0} : 4'd0;
    npend = modew ? (!d[0] && (m_run || (m_pend && !tk))) : (m_pend && !tk);
    m_irq  = |(m_flag & m_en);
    m_flag = (m_flag & ~((wr && a == 2'd3) ? d[3:0] : 4'd0)) | ev;
    if (wr && a == 2'd2) m_en = d[3:0];
    if (modew) m_run = d[0];
    m_pend = npend;
    if (clr) m_cnt = 8'd0;
    else if (adv) m_cnt = nx;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit wr, input bit [1:0] a, input bit [7:0] d);
    tick_i = tk; wr_en_i = wr; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    model_step(tk, wr, a, d);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic read(input bit [1:0] a, output bit [7:0] v);
    addr_i = a;
    #0.2;
    v = rdata_o;
  endtask

  task automatic check_all(input string req);
    bit [7:0] v;
    for (int a = 0; a < 4; a++) begin
      read(2'(a), v);
      check(req, $sformatf("reg%0d", a), v, exp_reg(2'(a)));
    end
    check(req, "irq_o", irq_o, m_irq);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state and no counting while stopped
    check_all("R1");
    ticks(5);
    read(2'd1, v); check("R1", "count stopped", v, 0);
    // R9 mode readback, R2/R3 eight ticks set 32 Hz flag
    step(1'b0, 1'b1, 2'd0, 8'h01);
    read(2'd0, v); check("R9", "mode run", v, 1);
    ticks(8);
    read(2'd1, v); check("R2", "count", v, 8);
    read(2'd3, v); check("R3", "flag 32Hz", v, 4'b0001);
    check("R6", "irq masked", irq_o, 0);
    // R6 enable, irq one cycle later
    step(1'b0, 1'b1, 2'd2, 8'h01);
    check("R6", "irq not yet", irq_o, 0);
    step(1'b0, 1'b0, 2'd0, 8'h00);
    check("R6", "irq up", irq_o, 1);
    // R4 write 0 then write 1
    step(1'b0, 1'b1, 2'd3, 8'h00);
    read(2'd3, v); check("R4", "write0 keeps", v, 1);
    step(1'b0, 1'b1, 2'd3, 8'h0f);
    read(2'd3, v); check("R4", "write1 clears", v, 0);
    step(1'b0, 1'b0, 2'd0, 8'h00);
    check("R6", "irq down", irq_o, 0);
    // R5 set wins: count 8 -> 15, then tick to 16 while clearing
    ticks(7);
    step(1'b1, 1'b1, 2'd3, 8'h0f);
    read(2'd3, v); check("R5", "set beats clear", v, 1);
    // R2 ignored write to count
    step(1'b0, 1'b1, 2'd1, 8'h55);
    read(2'd1, v); check("R2", "count write ignored", v, 16);
    // R7 stop across a 32 boundary
    step(1'b0, 1'b1, 2'd0, 8'h03);
    ticks(31);
    step(1'b0, 1'b1, 2'd3, 8'h0f);
    step(1'b0, 1'b1, 2'd0, 8'h00);
    read(2'd0, v); check("R9", "mode stop", v, 0);
    read(2'd1, v); check("R7", "still 31", v, 31);
    ticks(1);
    read(2'd1, v); check("R7", "last count", v, 32);
    read(2'd3, v); check("R7", "last count flags", v, 4'b0011);
    ticks(4);
    read(2'd1, v); check("R7", "halted", v, 32);
    // R8 clear with tick in same cycle, no flag
    step(1'b0, 1'b1, 2'd3, 8'h0f);
    step(1'b0, 1'b1, 2'd0, 8'h01);
    ticks(3);
    step(1'b1, 1'b1, 2'd0, 8'h03);
    read(2'd1, v); check("R8", "cleared", v, 0);
    read(2'd3, v); check("R8", "no flag", v, 0);
    read(2'd0, v); check("R8", "clr reads 0", v, 1);
    // R2 R3 full wrap to 1 Hz
    ticks(256);
    read(2'd1, v); check("R2", "wrap", v, 0);
    read(2'd3, v); check("R3", "all flags", v, 4'b1111);
    check_all("R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit tk, wr;
      bit [1:0] a;
      bit [7:0] d;
      tk = ($urandom % 3) != 0;
      wr = ($urandom % 5) == 0;
      a  = 2'($urandom % 4);
      d  = 8'($urandom);
      if (a == 2'd0 && ($urandom % 4) != 0) d[1] = 1'b0;
      if (a == 2'd0 && ($urandom % 3) != 0) d[0] = 1'b1;
      step(tk, wr, a, d);
      check_all("R2 R3 R4 R5 R6 R7 R8 R9");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule